// File: doc/BRIEF.md
# Serial Receive Status Buffer

This block is the receive-side holding register of a serial port. A receiver core pulses a load strobe. With that strobe it presents a 9-bit character and two error indications for that character: parity and framing. The block keeps the character and a set of sticky status flags: parity error, framing error, overrun, an error summary, and an optional arbitration-lost flag. A CPU-style register interface reads the flags and can clear them.

Software reads two bytes. The low byte holds character bits 7..0. Reading the low byte is signalled by a one-cycle `rd_lo` pulse, and that read has side effects. The high byte carries character bit 8 and the status flags. Software writes the high byte only to clear the arbitration-lost flag. Dropping either the serial-enable input or the receive-enable input clears all error state. The deserializer, interrupts and DMA are outside this block.

High byte layout: bit 0 = character bit 8, bits 2..1 = 0, bit 3 = arbitration lost, bit 4 = overrun, bit 5 = framing error, bit 6 = parity error, bit 7 = error summary.

Top module: `rx_status_buf`

## Requirements
- R1: A synchronous active-high reset clears the character, all flags and the unread state, so both bytes read 0x00.
- R2: A load strobe captures the 9-bit character. From the next cycle, the low byte shows bits 7..0 and high-byte bit 0 shows bit 8.
- R3: On each load, the parity flag (high bit 6) takes the parity indication and the framing flag (high bit 5) takes the framing indication.
- R4: An `rd_lo` pulse without a load in the same cycle clears the parity and framing flags. The overrun flag is left unchanged.
- R5: A load that arrives while the previous character is still unread sets overrun (high bit 4), and the new character overwrites the old one. Overrun stays set while enabled. A load in the same cycle as `rd_lo` is not an overrun.
- R6: The summary flag (high bit 7) is 1 exactly when any of the parity, framing or overrun flags is 1.
- R7: While `serial_en` or `rx_en` is 0, the parity, framing, overrun and summary flags read 0 from the next cycle, and any unread character is treated as read. The character itself and the arbitration flag are kept.
- R8: An `arb_lost` pulse sets the arbitration flag (high bit 3). A high-byte write with bit 3 = 0 clears it, and a write with bit 3 = 1 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R9: High-byte bits 2..1 always read 0. When the design is built with `ARB_EN = 0`, bit 3 also reads 0.
- R10: A high-byte write leaves the character and the parity, framing and overrun flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_en | input | 1 | Serial function enabled |
| rx_en | input | 1 | Reception enabled |
| ld_strobe | input | 1 | Receiver core delivers a character |
| ld_data | input | 9 | Delivered character |
| ld_parity_err | input | 1 | Parity error indication of that character |
| ld_frame_err | input | 1 | Framing error indication of that character |
| arb_lost | input | 1 | One-cycle pulse from the bus-arbitration logic |
| rd_lo | input | 1 | Software reads the low byte this cycle |
| wr_hi | input | 1 | Software writes the high byte this cycle |
| wr_data | input | 8 | High-byte write data |
| lo_byte | output | 8 | Low byte read value |
| hi_byte | output | 8 | High byte read value |

## Verification
Every result is due exactly one clock edge after its stimulus. This covers loads, the read side effect, disables, arbitration set and clear, and writes. The reason is that each flag and the character sit behind a single register, and both read bytes are combinational from those registers. The bench drives inputs 1 ns after a rising edge and advances one edge. It samples 1 ns later, so each check sees the first cycle in which the result must appear. The summary bit is combinational from the same registers, so it is checked in that same sample.

// File: rtl/rxsb_pkg.sv
package rxsb_pkg;
  localparam int BYTE_W  = 8;
  localparam int DATA_W  = BYTE_W + 1;
  localparam int ARB_POS = 3;

  typedef struct packed {
    logic per;
    logic fer;
    logic oer;
  } rxsb_err_t;

  function automatic logic err_any(rxsb_err_t e);
    return e.per | e.fer | e.oer;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_hi(logic d8, logic arb, rxsb_err_t e);
    return {err_any(e), e.per, e.fer, e.oer, arb, 2'b00, d8};
  endfunction
endpackage

// File: rtl/rxsb_char_reg.sv
module rxsb_char_reg #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              rd_lo,
  output logic [DATA_W-1:0] data_q,
  output logic              ovr_event
);
  logic pending;

  assign ovr_event = enable && ld && pending && !rd_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      pending <= 1'b0;
    end else begin
      if (ld) data_q <= ld_data;
      if (!enable)    pending <= 1'b0;
      else if (ld)    pending <= 1'b1;
      else if (rd_lo) pending <= 1'b0;
    end
  end

  p_load_data_r2: assert property (@(posedge clk) disable iff (rst)
    ld |=> data_q == $past(ld_data));
  p_hold_data_r10: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(data_q));
endmodule

// File: rtl/rxsb_err_flags.sv
module rxsb_err_flags
  import rxsb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      ld,
  input  logic      ld_per,
  input  logic      ld_fer,
  input  logic      rd_lo,
  input  logic      ovr_event,
  output rxsb_err_t err_q
);
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      err_q <= '0;
    end else begin
      if (ld) begin
        err_q.per <= ld_per;
        err_q.fer <= ld_fer;
      end else if (rd_lo) begin
        err_q.per <= 1'b0;
        err_q.fer <= 1'b0;
      end
      if (ovr_event) err_q.oer <= 1'b1;
    end
  end

  p_rd_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (enable && rd_lo && !ld) |=> (!err_q.per && !err_q.fer));
  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (enable && err_q.oer) |=> err_q.oer);
  p_ovr_set_r5: assert property (@(posedge clk) disable iff (rst)
    ovr_event |=> err_q.oer);
  p_disable_clears_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (err_q == '0));
endmodule

// File: rtl/rxsb_arb_flag.sv
module rxsb_arb_flag #(
  parameter bit ARB_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_pulse,
  input  logic clr_req,
  output logic arb_q
);
  generate
    if (ARB_EN) begin : g_arb
      logic arb_r;
      always_ff @(posedge clk) begin
        if (rst)            arb_r <= 1'b0;
        else if (set_pulse) arb_r <= 1'b1;
        else if (clr_req)   arb_r <= 1'b0;
      end
      assign arb_q = arb_r;

      p_arb_set_r8: assert property (@(posedge clk) disable iff (rst)
        set_pulse |=> arb_q);
      p_arb_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_pulse) |=> !arb_q);
      p_arb_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr_req && !set_pulse) |=> $stable(arb_q));
    end else begin : g_no_arb
      assign arb_q = 1'b0;

      p_arb_absent_r9: assert property (@(posedge clk) disable iff (rst)
        (set_pulse || clr_req) |=> !arb_q);
    end
  endgenerate
endmodule

// File: rtl/rx_status_buf.sv
module rx_status_buf
  import rxsb_pkg::*;
#(
  parameter bit ARB_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serial_en,
  input  logic              rx_en,
  input  logic              ld_strobe,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_parity_err,
  input  logic              ld_frame_err,
  input  logic              arb_lost,
  input  logic              rd_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte
);
  logic              rx_active;
  logic              ovr_event;
  logic              arb_clr;
  logic              arb_q;
  logic [DATA_W-1:0] data_q;
  rxsb_err_t         err_q;

  assign rx_active = serial_en && rx_en;
  assign arb_clr   = wr_hi && !wr_data[ARB_POS];

  rxsb_char_reg #(.DATA_W(DATA_W)) u_char (
    .clk(clk), .rst(rst), .enable(rx_active), .ld(ld_strobe),
    .ld_data(ld_data), .rd_lo(rd_lo), .data_q(data_q), .ovr_event(ovr_event)
  );

  rxsb_err_flags u_err (
    .clk(clk), .rst(rst), .enable(rx_active), .ld(ld_strobe),
    .ld_per(ld_parity_err), .ld_fer(ld_frame_err), .rd_lo(rd_lo),
    .ovr_event(ovr_event), .err_q(err_q)
  );

  rxsb_arb_flag #(.ARB_EN(ARB_EN)) u_arb (
    .clk(clk), .rst(rst), .set_pulse(arb_lost), .clr_req(arb_clr), .arb_q(arb_q)
  );

  assign lo_byte = data_q[BYTE_W-1:0];
  assign hi_byte = pack_hi(data_q[DATA_W-1], arb_q, err_q);

  p_summary_r6: assert property (@(posedge clk) disable iff (rst)
    hi_byte[7] == (hi_byte[6] | hi_byte[5] | hi_byte[4]));
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
    hi_byte[2:1] == 2'b00);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (lo_byte == '0 && hi_byte == '0));
endmodule

// File: tb/tb_rx_status_buf.sv
module tb_rx_status_buf;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serial_en = 1'b1, rx_en = 1'b1;
  logic       ld_strobe = 1'b0;
  logic [8:0] ld_data = '0;
  logic       ld_parity_err = 1'b0, ld_frame_err = 1'b0;
  logic       arb_lost = 1'b0, rd_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] lo_byte, hi_byte, lo_na, hi_na;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_status_buf dut (
    .clk(clk), .rst(rst), .serial_en(serial_en), .rx_en(rx_en),
    .ld_strobe(ld_strobe), .ld_data(ld_data), .ld_parity_err(ld_parity_err),
    .ld_frame_err(ld_frame_err), .arb_lost(arb_lost), .rd_lo(rd_lo),
    .wr_hi(wr_hi), .wr_data(wr_data), .lo_byte(lo_byte), .hi_byte(hi_byte)
  );

  rx_status_buf #(.ARB_EN(1'b0)) dut_na (
    .clk(clk), .rst(rst), .serial_en(serial_en), .rx_en(rx_en),
    .ld_strobe(ld_strobe), .ld_data(ld_data), .ld_parity_err(ld_parity_err),
    .ld_frame_err(ld_frame_err), .arb_lost(arb_lost), .rd_lo(rd_lo),
    .wr_hi(wr_hi), .wr_data(wr_data), .lo_byte(lo_na), .hi_byte(hi_na)
  );

  // Expected high byte: summary, parity, framing, overrun, arb, 0, 0, bit 8
  function automatic logic [7:0] exp_hi(logic d8, logic arb, logic ovr, logic fer, logic par);
    logic [7:0] v = 8'h00;
    v[0] = d8;
    v[3] = arb;
    v[4] = ovr;
    v[5] = fer;
    v[6] = par;
    v[7] = ovr || fer || par;
    return v;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ld_strobe = 0; ld_parity_err = 0; ld_frame_err = 0;
    arb_lost = 0; rd_lo = 0; wr_hi = 0; wr_data = '0;
  endtask

  task automatic load(logic [8:0] d, logic p, logic f, logic rd);
    ld_strobe = 1; ld_data = d; ld_parity_err = p; ld_frame_err = f; rd_lo = rd;
    step();
    idle();
  endtask

  task automatic read_lo();
    rd_lo = 1;
    step();
    idle();
  endtask

  task automatic t_reset();
    rst = 1; step(); step(); rst = 0;
    chk("R1 lo", lo_byte, 8'h00);
    chk("R1 hi", hi_byte, 8'h00);
  endtask

  task automatic t_load_plain();
    load(9'h1A5, 0, 0, 0);
    chk("R2 lo", lo_byte, 8'hA5);
    chk("R2 hi", hi_byte, exp_hi(1, 0, 0, 0, 0));
    read_lo();
    chk("R4 read no error", hi_byte, exp_hi(1, 0, 0, 0, 0));
  endtask

  task automatic t_errors();
    load(9'h03C, 1, 0, 0);
    chk("R3 parity", hi_byte, exp_hi(0, 0, 0, 0, 1));
    read_lo();
    chk("R4 parity cleared", hi_byte, exp_hi(0, 0, 0, 0, 0));
    load(9'h0FF, 0, 1, 0);
    chk("R3 framing", hi_byte, exp_hi(0, 0, 0, 1, 0));
    load(9'h155, 0, 0, 0);
    chk("R5 overrun data", lo_byte, 8'h55);
    chk("R5 overrun flag", hi_byte, exp_hi(1, 0, 1, 0, 0));
    read_lo();
    chk("R4 overrun kept", hi_byte, exp_hi(1, 0, 1, 0, 0));
    wr_hi = 1; wr_data = 8'hFF; step(); idle();
    chk("R10 flags after write", hi_byte, exp_hi(1, 0, 1, 0, 0));
    chk("R10 data after write", lo_byte, 8'h55);
    rx_en = 0; step(); rx_en = 1;
    chk("R7 rx disable", hi_byte, exp_hi(1, 0, 0, 0, 0));
    chk("R7 data kept", lo_byte, 8'h55);
  endtask

  task automatic t_serial_disable();
    load(9'h022, 1, 1, 0);
    chk("R3 both", hi_byte, exp_hi(0, 0, 0, 1, 1));
    serial_en = 0; step(); serial_en = 1;
    chk("R7 serial disable", hi_byte, exp_hi(0, 0, 0, 0, 0));
    load(9'h111, 0, 0, 0);
    chk("R7 unread cleared", hi_byte, exp_hi(1, 0, 0, 0, 0));
  endtask

  task automatic t_read_with_load();
    load(9'h0AA, 0, 0, 1);
    chk("R5 load with read", hi_byte, exp_hi(0, 0, 0, 0, 0));
    chk("R2 low", lo_byte, 8'hAA);
    read_lo();
  endtask

  task automatic t_arb();
    arb_lost = 1; step(); idle();
    chk("R8 set", hi_byte, exp_hi(0, 1, 0, 0, 0));
    chk("R9 no arb variant", hi_na & 8'h0E, 8'h00);
    wr_hi = 1; wr_data = 8'h08; step(); idle();
    chk("R8 write one", hi_byte, exp_hi(0, 1, 0, 0, 0));
    rx_en = 0; step(); rx_en = 1;
    chk("R7 arb kept", hi_byte, exp_hi(0, 1, 0, 0, 0));
    wr_hi = 1; wr_data = 8'hF7; step(); idle();
    chk("R8 write zero", hi_byte, exp_hi(0, 0, 0, 0, 0));
    arb_lost = 1; wr_hi = 1; wr_data = 8'h00; step(); idle();
    chk("R8 set wins", hi_byte, exp_hi(0, 1, 0, 0, 0));
    chk("R9 unused bits", hi_byte & 8'h06, 8'h00);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_load_plain();
    t_errors();
    t_serial_disable();
    t_read_with_load();
    t_arb();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule